// File: doc/BRIEF.md
# Staggered Integrate-and-Dump Decimator

This block thins a stream of signed phase-error samples by a factor `DECIM` (M) while low-pass filtering it with a rectangular moving sum that spans 2M samples. Each decimated output is the mean of the 2M most recent accepted inputs. Consecutive outputs therefore share M samples.

The filter is built from two identical integrate-and-dump accumulators. Both are driven by one shared phase counter. Each accumulator collects 2M samples and then dumps. The second accumulator's windows begin M samples after the first one's, so the two dumps fall halfway between each other. A one-hot output selector registers whichever accumulator has just dumped, and the two sources alternate.

The division by 2M is a right shift with sign. This is why 2M must be a power of two. Inputs arrive with a qualifier strobe, and cycles without that strobe do not count toward any window.

Top module: `stag_boxcar_decim`

## Requirements
- R1: While reset is held low and on the first cycle after it, `out_valid` is 0 and `out_data` is 0.
- R2: The first 2M accepted samples after reset produce no output strobe.
- R3: After reset, count accepted samples from k = 0. The sample with index k produces exactly one `out_valid` pulse, one clock after it is accepted, when k ≥ 2M and (k − 2M) is a multiple of M. No other sample produces a pulse.
- R4: The output value for sample k is floor(sum of samples k−2M … k−1 divided by 2M). Negative sums round toward minus infinity.
- R5: Consecutive outputs come from windows offset by M samples. The windows overlap by M samples, and their sources alternate between the two accumulators.
- R6: The sample that triggers an output is not part of that output's window. It is the first sample of the next window of the accumulator that dumped. No sample is dropped or counted twice at a boundary.
- R7: A cycle with `in_valid` low does not advance the phase and does not change any sum, whatever the value on `in_data`.
- R8: `out_data` keeps its value in every cycle where `out_valid` is low.
- R9: Full-scale inputs do not wrap. 2M samples of the largest positive value give that value, and 2M samples of the most negative value give that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Qualifies `in_data` for this cycle |
| in_data | input | DATA_W | Signed two's-complement input sample |
| out_valid | output | 1 | One-cycle strobe marking a new decimated sample |
| out_data | output | DATA_W | Signed filtered and decimated sample |

## Verification
On every boundary sample, two things happen in the same cycle. One accumulator finishes its window, emits it and reloads with the incoming sample. The other accumulator keeps adding that same sample to its half-finished window. The bench provokes this with isolated impulses placed exactly on dump samples. The scoreboard then judges whether each impulse shows up in exactly the windows that R6 assigns to it. A second collision, an idle cycle that lands on an expected dump slot, is provoked by random gaps. Such a cycle must delay the strobe rather than fire it, and the monitor checks this against the count of accepted samples.

// File: rtl/sbd_pkg.sv
package sbd_pkg;

   // Number of accumulators working in staggered phase.
   localparam int UNIT_COUNT = 2;

   function automatic bit is_pow2(input int value);
      return (value > 0) && ((value & (value - 1)) == 0);
   endfunction

endpackage

// File: rtl/sbd_phase_ctrl.sv
module sbd_phase_ctrl #(
   parameter int DECIM     = 4,
   parameter int NUM_UNITS = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   output logic [NUM_UNITS-1:0] dump
);
   localparam int SPAN  = 2 * DECIM;
   localparam int CNT_W = (SPAN > 1) ? $clog2(SPAN) : 1;

   logic [CNT_W-1:0] phase;

   // Wraps naturally because SPAN is a power of two.
   always_ff @(posedge clk) begin
      if (!rst_n)
         phase <= '0;
      else if (in_valid)
         phase <= phase + 1'b1;
   end

   // Unit u closes its window on the sample arriving at phase u*DECIM.
   for (genvar u = 0; u < NUM_UNITS; u++) begin : g_dump
      assign dump[u] = in_valid && (phase == CNT_W'(u * DECIM));
   end

   // R3: at most one unit closes a window on any sample
   p_one_dump_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dump));

   // R7: the phase does not move on an idle cycle
   p_phase_hold_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(phase));

endmodule

// File: rtl/sbd_dump_acc.sv
module sbd_dump_acc #(
   parameter int DATA_W = 12,
   parameter int DECIM  = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic                     dump,
   input  logic signed [DATA_W-1:0] in_data,
   output logic                     fire,
   output logic signed [DATA_W-1:0] result
);
   localparam int SPAN  = 2 * DECIM;
   localparam int SHIFT = $clog2(SPAN);
   localparam int ACC_W = DATA_W + SHIFT;

   logic signed [ACC_W-1:0] acc;
   logic signed [ACC_W-1:0] sample_ext;
   logic signed [ACC_W-1:0] acc_scaled;
   logic                    primed;

   assign sample_ext = {{SHIFT{in_data[DATA_W-1]}}, in_data};

   // Arithmetic shift: negative sums round toward minus infinity.
   assign acc_scaled = acc >>> SHIFT;
   assign result     = acc_scaled[DATA_W-1:0];

   // A unit only emits once it has integrated a complete window.
   assign fire = dump && primed;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc    <= '0;
         primed <= 1'b0;
      end else if (in_valid) begin
         if (dump) begin
            // The boundary sample opens the next window.
            acc    <= sample_ext;
            primed <= 1'b1;
         end else begin
            acc <= acc + sample_ext;
         end
      end
   end

   // R2: once primed, a unit stays primed until reset
   p_primed_sticky_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      primed |=> primed);

   // R7: idle cycles leave the running sum untouched
   p_acc_hold_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(acc));

endmodule

// File: rtl/sbd_out_sel.sv
module sbd_out_sel #(
   parameter int DATA_W    = 12,
   parameter int NUM_UNITS = 2
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [NUM_UNITS-1:0]              fire,
   input  logic [NUM_UNITS-1:0][DATA_W-1:0]  results,
   output logic                              out_valid,
   output logic signed [DATA_W-1:0]          out_data
);
   logic [DATA_W-1:0] picked;

   // One-hot OR mux.
   always_comb begin
      picked = '0;
      for (int u = 0; u < NUM_UNITS; u++) begin
         if (fire[u])
            picked = picked | results[u];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= |fire;
         if (|fire)
            out_data <= picked;
      end
   end

   // Tracks the previous source for the alternation check.
   logic [NUM_UNITS-1:0] prev_fire;
   logic                 any_seen;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_fire <= '0;
         any_seen  <= 1'b0;
      end else if (|fire) begin
         prev_fire <= fire;
         any_seen  <= 1'b1;
      end
   end

   // R3: never two sources in one cycle
   p_single_source_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(fire));

   // R5: successive outputs alternate between the accumulators
   p_alternate_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (|fire && any_seen) |-> (fire != prev_fire));

   // R8: output value holds between strobes
   p_hold_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> $stable(out_data));

endmodule

// File: rtl/stag_boxcar_decim.sv
module stag_boxcar_decim #(
   parameter int DATA_W = 12,
   parameter int DECIM  = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic signed [DATA_W-1:0] in_data,
   output logic                     out_valid,
   output logic signed [DATA_W-1:0] out_data
);
   localparam int NUM_UNITS = sbd_pkg::UNIT_COUNT;

   if (!sbd_pkg::is_pow2(DECIM)) begin : g_bad_decim
      $error("DECIM must be a power of two so the window length is one too");
   end
   if (DATA_W < 2) begin : g_bad_width
      $error("DATA_W must be at least 2");
   end

   logic [NUM_UNITS-1:0]             dump;
   logic [NUM_UNITS-1:0]             fire;
   logic [NUM_UNITS-1:0][DATA_W-1:0] results;

   sbd_phase_ctrl #(
      .DECIM     (DECIM),
      .NUM_UNITS (NUM_UNITS)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .dump     (dump)
   );

   for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
      logic signed [DATA_W-1:0] unit_result;

      sbd_dump_acc #(
         .DATA_W (DATA_W),
         .DECIM  (DECIM)
      ) u_acc (
         .clk      (clk),
         .rst_n    (rst_n),
         .in_valid (in_valid),
         .dump     (dump[u]),
         .in_data  (in_data),
         .fire     (fire[u]),
         .result   (unit_result)
      );

      assign results[u] = unit_result;
   end

   sbd_out_sel #(
      .DATA_W    (DATA_W),
      .NUM_UNITS (NUM_UNITS)
   ) u_sel (
      .clk       (clk),
      .rst_n     (rst_n),
      .fire      (fire),
      .results   (results),
      .out_valid (out_valid),
      .out_data  (out_data)
   );

   // R3: a strobe is always caused by an accepted sample one cycle earlier
   p_strobe_cause_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid));

endmodule

// File: tb/stag_boxcar_decim_test.sv
`timescale 1ns/1ps
module stag_boxcar_decim_test;
   localparam int DW   = 12;
   localparam int M    = 4;
   localparam int L    = 2 * M;
   localparam int MAXV = (1 << (DW - 1)) - 1;
   localparam int MINV = -(1 << (DW - 1));

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 in_valid = 1'b0;
   logic signed [DW-1:0] in_data = '0;
   logic                 out_valid;
   logic signed [DW-1:0] out_data;

   stag_boxcar_decim #(.DATA_W(DW), .DECIM(M)) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .out_valid (out_valid),
      .out_data  (out_data)
   );

   always #2.5 clk = ~clk;

   int    checks = 0;
   int    errors = 0;
   int    exp_q[$];
   string req_q[$];
   int    hist[$];
   bit    due = 1'b0;
   bit    running = 1'b0;
   int    last_out = 0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int floor_div(input int s);
      int q;
      q = s / L;
      if ((s % L) != 0 && s < 0) q = q - 1;
      return q;
   endfunction

   // Driver: presents one accepted sample and predicts any output it causes.
   task automatic send(input int x, input string req);
      int k;
      int s;
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = DW'(x);
      hist.push_back(x);
      k   = hist.size() - 1;
      due = 1'b0;
      if (k >= L && ((k - L) % M) == 0) begin
         s = 0;
         for (int i = k - L; i < k; i++) s += hist[i];
         exp_q.push_back(floor_div(s));
         req_q.push_back(req);
         due = 1'b1;
      end
   endtask

   // Idle cycles carry garbage data that must be ignored (R7).
   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         in_data  = DW'($urandom);
         due      = 1'b0;
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      running  = 1'b0;
      rst_n    = 1'b0;
      in_valid = 1'b0;
      due      = 1'b0;
      exp_q.delete();
      req_q.delete();
      hist.delete();
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
      check(out_data == '0, "R1 out_data in reset", int'(out_data), 0);
      rst_n    = 1'b1;
      last_out = 0;
      running  = 1'b1;
   endtask

   // Monitor / scoreboard, sampled between edges.
   always begin
      @(posedge clk);
      #1;
      if (rst_n && running) begin
         if (due) begin
            check(out_valid == 1'b1, "R3 strobe on due sample", int'(out_valid), 1);
            if (exp_q.size() > 0) begin
               int    e;
               string r;
               e = exp_q.pop_front();
               r = req_q.pop_front();
               if (out_valid)
                  check(int'(out_data) == e, r, int'(out_data), e);
            end
         end else begin
            check(out_valid == 1'b0,
                  (hist.size() <= L) ? "R2 no strobe during warm-up" : "R3 no extra strobe",
                  int'(out_valid), 0);
            check(int'(out_data) == last_out, "R8 hold between strobes",
                  int'(out_data), last_out);
         end
         if (out_valid) last_out = int'(out_data);
      end
   end

   initial begin
      #(200000 * 5);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      do_reset();
      @(negedge clk);
      check(out_valid == 1'b0 && out_data == '0, "R1 first cycle after reset",
            int'(out_data), 0);

      // Ramp: basic averaging with overlapping windows.
      for (int i = 1; i <= 40; i++) send(i * 7, "R4 ramp average");
      idle(2);

      // Alternating -1/0: mean -0.5 must floor to -1.
      for (int i = 0; i < 24; i++) send((i % 2 == 0) ? -1 : 0, "R4 floor of negative");
      idle(2);

      // Boundary impulses on dump samples.
      do_reset();
      for (int i = 0; i < 40; i++)
         send(((i % M) == 0 && i >= L) ? 64 : 0, "R6 boundary sample ownership");
      idle(2);

      // Full scale both ways.
      for (int i = 0; i < 24; i++) send(MAXV, "R9 positive full scale");
      for (int i = 0; i < 24; i++) send(MINV, "R9 negative full scale");
      idle(2);

      // Gaps between accepted samples, including on dump slots.
      for (int i = 0; i < 60; i++) begin
         send($urandom_range(0, 4095) - 2048, "R7 gaps ignored");
         idle($urandom_range(0, 3));
      end
      idle(2);

      // Reset in the middle of a stream, then warm-up again.
      for (int i = 0; i < 5; i++) send(300, "R2 before reset");
      do_reset();
      for (int i = 0; i < 20; i++) send(-100 + i, "R2 warm-up after reset");
      idle(2);

      // Long random stream: overlap and alternation by value.
      for (int i = 0; i < 300; i++) send($urandom_range(0, 4095) - 2048, "R5 overlapped windows");
      idle(3);

      check(exp_q.size() == 0, "R3 all predicted outputs seen", exp_q.size(), 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule